// File: doc/BRIEF.md
# Clock-Mode Step Divider

This block lets one fast master clock stand in for the slower clock sources and PLL multiplier settings of a small microcontroller. A free-running 13-bit accumulator adds a step on every master-clock edge. The step has at most one bit set. Which bit is set depends on a 7-bit clock-mode word and a boot input.

The higher the step bit, the faster the upper accumulator bits toggle. The top bit is exported as the derived core clock, and the bit below it as the emulated PLL clock. A mode that matches no defined pattern gives a zero step, so the accumulator holds its value. A separate synchronous initialisation input clears the accumulator.

Top module: `mode_step_divider`

## Requirements
- R1: While init_i is high at a clock edge, count_o is 0 after that edge. init_i overrides boot_i and every mode.
- R2: At each edge with init_i low, count_o becomes (count_o + step) mod 8192. The step is zero or a single power of two.
- R3: While boot_i is high, the step is 4096 whatever mode_i holds. With boot_i low, mode_i[6:5]=11 and mode_i[2:0]=111 also give step 4096.
- R4: With boot_i low and mode_i[6:5]=11, mode_i[2:0]=110 gives step 2048 and mode_i[2:0]=101 gives step 1024.
- R5: With boot_i low, step 512 comes from either of two modes: mode_i[2:0]=000 with any upper bits, or mode_i[6:5]=11 with mode_i[2:0]=100.
- R6: With boot_i low, step 256 comes from either of two modes: mode_i[6:5]=11 with mode_i[2:0]=011, or mode_i[5]=1 with mode_i[2:0]=010.
- R7: With boot_i low, mode_i[2:0]=001 gives step 1, whatever the upper bits hold.
- R8: With boot_i low, any mode that matches none of the patterns in R3 to R7 leaves count_o unchanged. Examples are mode_i[2:0]=010 with mode_i[5]=0, and mode_i[6:5]!=11 with mode_i[2:0] in 011..111.
- R9: core_clk_o always equals count_o[12], and pll_clk_o always equals count_o[11].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast master clock |
| init_i | input | 1 | Synchronous clear of the accumulator, active high |
| boot_i | input | 1 | Boot/reset request; forces the fastest step |
| mode_i | input | 7 | Clock-mode word selecting the step |
| count_o | output | 13 | Accumulator value |
| core_clk_o | output | 1 | Derived core clock (accumulator top bit) |
| pll_clk_o | output | 1 | Emulated PLL clock (accumulator bit 11) |

## Verification
Two inputs can act in the same cycle in two ways. The first is boot_i with a slow mode already on mode_i: the bench holds both and expects steps of 4096, with no slow step added on top. The second is init_i with boot_i: the bench raises both together and expects zero. A reference model in the bench computes the expected accumulator from the mode table for every cycle. A scoreboard compares each value, and both derived clock outputs, one edge later. The runs cover accumulator wrap-around and unmatched modes.

// File: rtl/mode_step_divider.sv
module mode_step_divider #(
  parameter int CNT_W  = 13,
  parameter int MODE_W = 7
) (
  input  logic              clk_i,
  input  logic              init_i,
  input  logic              boot_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              core_clk_o,
  output logic              pll_clk_o
);
  localparam int P16 = CNT_W - 1;
  localparam int P8  = CNT_W - 2;
  localparam int P4  = CNT_W - 3;
  localparam int P2  = CNT_W - 4;
  localparam int P1  = CNT_W - 5;

  logic [2:0] sel;
  logic       ext, xtal;
  logic [CNT_W-1:0] step;

  assign sel  = mode_i[2:0];
  assign ext  = mode_i[6] & mode_i[5];
  assign xtal = mode_i[5];

  always_comb begin
    step      = '0;
    step[P16] = boot_i | (ext & (sel == 3'd7));
    step[P8]  = ~boot_i & ext & (sel == 3'd6);
    step[P4]  = ~boot_i & ext & (sel == 3'd5);
    step[P2]  = ~boot_i & ((ext & (sel == 3'd4)) | (sel == 3'd0));
    step[P1]  = ~boot_i & ((ext & (sel == 3'd3)) | (xtal & (sel == 3'd2)));
    step[0]   = ~boot_i & (sel == 3'd1);
  end

  always_ff @(posedge clk_i) begin
    if (init_i) count_o <= '0;
    else        count_o <= count_o + step;
  end

  assign core_clk_o = count_o[P16];
  assign pll_clk_o  = count_o[P8];
endmodule

// File: rtl/mode_step_divider_chk.sv
module mode_step_divider_chk #(
  parameter int CNT_W  = 13,
  parameter int MODE_W = 7
) (
  input logic              clk_i,
  input logic              init_i,
  input logic              boot_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              core_clk_o,
  input logic              pll_clk_o
);
  localparam logic [CNT_W-1:0] TOP = {1'b1, {(CNT_W-1){1'b0}}};
  logic vld = 1'b0;
  always_ff @(posedge clk_i) vld <= 1'b1;

  a_r1_init_clear: assert property (@(posedge clk_i)
    init_i |=> count_o == '0);

  a_r2_onehot_step: assert property (@(posedge clk_i) disable iff (init_i)
    vld && !$past(init_i) |-> $onehot0(count_o - $past(count_o)));

  a_r3_boot_top: assert property (@(posedge clk_i) disable iff (init_i)
    vld && boot_i |=> count_o == CNT_W'($past(count_o) + TOP));

  a_r7_slow_unit: assert property (@(posedge clk_i) disable iff (init_i)
    vld && !boot_i && mode_i[2:0] == 3'b001 |=> count_o == CNT_W'($past(count_o) + 1'b1));

  a_r8_unmatched_hold: assert property (@(posedge clk_i) disable iff (init_i)
    vld && !boot_i && !mode_i[5] && mode_i[2:0] == 3'b010 |=> $stable(count_o));
endmodule

bind mode_step_divider mode_step_divider_chk #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_chk (
  .clk_i(clk_i), .init_i(init_i), .boot_i(boot_i), .mode_i(mode_i),
  .count_o(count_o), .core_clk_o(core_clk_o), .pll_clk_o(pll_clk_o));

// File: tb/test_mode_step_divider.sv
module test_mode_step_divider;
  logic        clk = 1'b0;
  logic        init_i = 1'b1, boot_i = 1'b0;
  logic [6:0]  mode_i = 7'd0;
  logic [12:0] count_o;
  logic        core_clk_o, pll_clk_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [12:0] ref_cnt = '0;
  logic [12:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mode_step_divider i_mode_step_divider (
    .clk_i(clk), .init_i(init_i), .boot_i(boot_i), .mode_i(mode_i),
    .count_o(count_o), .core_clk_o(core_clk_o), .pll_clk_o(pll_clk_o));

  function automatic logic [12:0] ref_step(input logic [6:0] m, input logic b);
    if (b) return 13'd4096;
    casez (m)
      7'b11??111: return 13'd4096;
      7'b11??110: return 13'd2048;
      7'b11??101: return 13'd1024;
      7'b11??100, 7'b????000: return 13'd512;
      7'b11??011, 7'b?1??010: return 13'd256;
      7'b????001: return 13'd1;
      default: return 13'd0;
    endcase
  endfunction

  task automatic drive(input logic [6:0] m, input logic b, input logic ini,
                       input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      mode_i = m; boot_i = b; init_i = ini;
      ref_cnt = ini ? 13'd0 : ref_cnt + ref_step(m, b);
      exp_q.push_back(ref_cnt);
      tag_q.push_back(tag);
    end
  endtask

  task automatic judge(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [12:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        judge(t, "count", int'(count_o), int'(e));
        judge("R9", "core_clk", int'(core_clk_o), int'(e[12]));
        judge("R9", "pll_clk", int'(pll_clk_o), int'(e[11]));
      end
    end
  end

  initial begin
    drive(7'b0000000, 1'b0, 1'b1, 3, "R1");
    drive(7'b0000001, 1'b0, 1'b0, 40, "R7");
    drive(7'b1010001, 1'b0, 1'b0, 10, "R7");
    drive(7'b0110000, 1'b0, 1'b0, 40, "R5");
    drive(7'b1100100, 1'b0, 1'b0, 20, "R5");
    drive(7'b1100111, 1'b0, 1'b0, 10, "R3");
    drive(7'b1111110, 1'b0, 1'b0, 20, "R4");
    drive(7'b1100101, 1'b0, 1'b0, 20, "R4");
    drive(7'b1100011, 1'b0, 1'b0, 20, "R6");
    drive(7'b0100010, 1'b0, 1'b0, 20, "R6");
    drive(7'b0000001, 1'b1, 1'b0, 10, "R3");
    drive(7'b0000010, 1'b0, 1'b0, 10, "R8");
    drive(7'b1000111, 1'b0, 1'b0, 10, "R8");
    drive(7'b0101011, 1'b0, 1'b0, 10, "R8");
    drive(7'b1100110, 1'b0, 1'b0, 9, "R2");
    drive(7'b0000001, 1'b1, 1'b1, 3, "R1");
    drive(7'b0000001, 1'b0, 1'b0, 8300, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule